// File: doc/BRIEF.md
# Translation Unit Performance Counter Bank

This block counts activity of an I/O address-translation unit. It holds one free-running cycle counter and a parameterised number (1 to 31) of event counters. Every event counter owns a selector that names which of eight translation events it counts. The selector can also limit counting to events whose tags match a programmed device or guest context ID and/or a process or process context ID. A device ID compare may cover an aligned power-of-two range of IDs. When a counter wraps, a sticky overflow flag is set and a level interrupt-pending output rises. Software clears the output through a write-one-to-clear register.

Software reaches the bank over a 32-bit register bus with a word address. Every write completes in one cycle and reads are combinational. A 64-bit register is accessed as two 32-bit words, low word at the lower address. Unimplemented counters and counter bits are hard-wired to zero. Software finds the counter count and the counter width by writing all ones and reading the value back. The event inputs carry one pulse bit per event type and one shared set of ID tags for the cycle.

Top module: `tpb_top`

## Requirements
- R1: After reset every counter reads zero, all overflow flags and the overflow status word (byte offset 0x58) read zero, `irq_pend` is low, and the inhibit word (0x5C) reads with bit 0 and bits 1..NUM_CTR set.
- R2: The inhibit word at 0x5C keeps only bit 0 (cycle counter) and bits 1..NUM_CTR (event counter n in bit n); all other bits read zero whatever is written.
- R3: Event counter n sits at 0x60+8n (low word) and 0x64+8n (high word) and keeps only CTR_W bits; counters above NUM_CTR read zero. The cycle counter sits at 0x60/0x64 and keeps CYC_W count bits, with its overflow flag in bit 31 of the high word.
- R4: The cycle counter adds one on every clock while inhibit bit 0 is clear.
- R5: A counter whose inhibit bit is set holds its value whatever events arrive.
- R6: The selector of counter n is at 0x160+8(n-1) (low) and +4 (high); its event ID (low-word bits 14:0) k in 1..8 counts cycles where evt_pulse[k-1] is high, ID 0 never counts, and pulses of other event types are ignored.
- R7: With device-valid (high-word bit 29) set, an event counts only if its device tag equals the device field (high-word bits 27:4). ID-type (high-word bit 30) clear compares tag_did, set compares tag_gscid.
- R8: With process-valid (high-word bit 28) set, an event counts only if its process tag equals the 20-bit process field (low-word bits 31:16, high-word bits 3:0). ID-type clear compares tag_pid, set compares tag_pscid.
- R9: With partial match (low-word bit 15) set, the device compare ignores every bit up to and including the lowest clear bit of the device field.
- R10: When a counter wraps from all ones to zero, its overflow flag is set (selector high-word bit 31, or cycle high-word bit 31), which shows in overflow status bit n (bit 0 for cycles), and `irq_pend` rises on the next clock.
- R11: `irq_pend` stays high until 1 is written to bit 0 of 0x50. Overflow flags stay set until software writes their bit to zero.
- R12: A software write to a counter word wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 10 | Word address (byte offset bits 11:2) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_waddr, combinational |
| evt_pulse | input | 8 | One bit per event type; bit k is event ID k+1 |
| tag_did | input | 24 | Device ID of this cycle's events |
| tag_pid | input | 20 | Process ID of this cycle's events |
| tag_gscid | input | 24 | Guest context ID of this cycle's events |
| tag_pscid | input | 20 | Process context ID of this cycle's events |
| irq_pend | output | 1 | Level overflow interrupt pending |

## Verification
Reads are combinational, so register state changes can be seen in the cycle after the edge that changes them. A write or event pulse applied in cycle k shows on `reg_rdata` after edge k. The interrupt output rises at the same edge as the wrapping counter. The bench drives every stimulus on the falling edge, holds an event for exactly n rising edges, and samples one nanosecond after a later falling edge. Each expected count is the exact number of qualifying edges, and cycle-counter checks compare two samples taken a known number of edges apart.

// File: rtl/tpb_pkg.sv
// Shared constants, register offsets and the selector layout of the
// performance counter bank. Assumes a 12-bit byte address space.
package tpb_pkg;
    localparam int EVT_ID_W      = 15;
    localparam int NUM_EVT_TYPES = 8;
    localparam int DEV_W         = 24;
    localparam int PROC_W        = 20;
    localparam int WADDR_W       = 10;

    localparam logic [11:0] OFF_IRQ     = 12'h050;
    localparam logic [11:0] OFF_OVF     = 12'h058;
    localparam logic [11:0] OFF_INH     = 12'h05C;
    localparam logic [11:0] OFF_CTR     = 12'h060;
    localparam logic [11:0] OFF_SEL     = 12'h160;
    localparam logic [11:0] OFF_SEL_END = 12'h258;

    // Selector bits 62:0; bit 63 (overflow flag) lives with the counter.
    typedef struct packed {
        logic              idt;
        logic              dv;
        logic              pv;
        logic [DEV_W-1:0]  dev;
        logic [PROC_W-1:0] proc_id;
        logic              pmask;
        logic [EVT_ID_W-1:0] evt;
    } sel_t;
endpackage

// File: rtl/tpb_filter.sv
// ID filter of one event counter. Picks device/process tags or guest/process
// context tags by the ID-type bit and compares the enabled fields. Partial
// match widens the device compare to an aligned power-of-two range.
// Purely combinational.
module tpb_filter
    import tpb_pkg::*;
(
    input  logic              idt,
    input  logic              dv,
    input  logic              pv,
    input  logic              pmask,
    input  logic [DEV_W-1:0]  dev,
    input  logic [PROC_W-1:0] proc_id,
    input  logic [DEV_W-1:0]  tag_did,
    input  logic [DEV_W-1:0]  tag_gscid,
    input  logic [PROC_W-1:0] tag_pid,
    input  logic [PROC_W-1:0] tag_pscid,
    output logic              hit
);
    logic [DEV_W-1:0]  dev_tag;
    logic [PROC_W-1:0] proc_tag;
    logic [DEV_W-1:0]  ign;
    logic              dev_ok;
    logic              proc_ok;

    // Tag choice by ID type.
    assign dev_tag  = idt ? tag_gscid : tag_did;
    assign proc_tag = idt ? tag_pscid : tag_pid;
    // Bits up to and including the lowest clear bit are don't-care.
    assign ign      = pmask ? (dev ^ (dev + DEV_W'(1))) : '0;
    assign dev_ok   = !dv || (((dev_tag ^ dev) & ~ign) == '0);
    assign proc_ok  = !pv || (proc_tag == proc_id);
    assign hit      = dev_ok && proc_ok;
endmodule

// File: rtl/tpb_evt_ctr.sv
// One event counter with its selector and overflow flag. Assumes
// 32 < CTR_W <= 64. A software write to either counter word replaces that
// word and suppresses the same-cycle increment.
module tpb_evt_ctr
    import tpb_pkg::*;
#(
    parameter int CTR_W = 40
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_EVT_TYPES-1:0] evt_pulse,
    input  logic [DEV_W-1:0]         tag_did,
    input  logic [DEV_W-1:0]         tag_gscid,
    input  logic [PROC_W-1:0]        tag_pid,
    input  logic [PROC_W-1:0]        tag_pscid,
    input  logic                     inhibit,
    input  logic                     wr_cnt_lo,
    input  logic                     wr_cnt_hi,
    input  logic                     wr_sel_lo,
    input  logic                     wr_sel_hi,
    input  logic [31:0]              wdata,
    output logic [CTR_W-1:0]         cnt_q,
    output sel_t                     sel_q,
    output logic                     of_q,
    output logic                     wrap
);
    localparam logic [CTR_W-1:0] LO_MASK = CTR_W'(64'hFFFF_FFFF);

    logic             filt_hit;
    logic             ev_hit;
    logic             inc;
    logic             cnt_wr;
    logic [CTR_W-1:0] cnt_wv;
    logic [62:0]      sel_r;

    assign sel_q = sel_t'(sel_r);

    tpb_filter u_filt (
        .idt      (sel_q.idt),
        .dv       (sel_q.dv),
        .pv       (sel_q.pv),
        .pmask    (sel_q.pmask),
        .dev      (sel_q.dev),
        .proc_id  (sel_q.proc_id),
        .tag_did  (tag_did),
        .tag_gscid(tag_gscid),
        .tag_pid  (tag_pid),
        .tag_pscid(tag_pscid),
        .hit      (filt_hit)
    );

    // Pick the pulse of the selected event type; ID 0 and IDs above 8 never hit.
    always_comb begin
        ev_hit = 1'b0;
        for (int k = 0; k < NUM_EVT_TYPES; k++) begin
            if (sel_q.evt == EVT_ID_W'(k + 1)) ev_hit = ev_hit | evt_pulse[k];
        end
    end

    assign inc    = ev_hit && filt_hit && !inhibit;
    assign cnt_wr = wr_cnt_lo || wr_cnt_hi;
    assign wrap   = inc && !cnt_wr && (cnt_q == '1);
    assign cnt_wv = wr_cnt_lo ? ((cnt_q & ~LO_MASK) | CTR_W'(wdata))
                              : ((cnt_q & LO_MASK) | CTR_W'({wdata, 32'd0}));

    // Count value: software write first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= cnt_wv;
        else if (inc)    cnt_q <= cnt_q + CTR_W'(1);
    end

    // Selector fields, written a word at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_r <= '0;
        else if (wr_sel_lo) sel_r[31:0]  <= wdata;
        else if (wr_sel_hi) sel_r[62:32] <= wdata[30:0];
    end

    // Sticky overflow flag; software write wins over a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)         of_q <= 1'b0;
        else if (wr_sel_hi) of_q <= wdata[31];
        else if (wrap)      of_q <= 1'b1;
    end
endmodule

// File: rtl/tpb_cyc_ctr.sv
// Free-running cycle counter with a sticky overflow flag kept in bit 31 of
// its high word. Assumes 32 < CYC_W <= 63. Software writes beat increments.
module tpb_cyc_ctr #(
    parameter int CYC_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inhibit,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [31:0]      wdata,
    output logic [CYC_W-1:0] cnt_q,
    output logic             of_q,
    output logic             wrap
);
    localparam logic [CYC_W-1:0] LO_MASK = CYC_W'(64'hFFFF_FFFF);

    logic             inc;
    logic [CYC_W-1:0] cnt_wv;

    assign inc    = !inhibit;
    assign wrap   = inc && !(wr_lo || wr_hi) && (cnt_q == '1);
    assign cnt_wv = wr_lo ? ((cnt_q & ~LO_MASK) | CYC_W'(wdata))
                          : ((cnt_q & LO_MASK) | CYC_W'({wdata[30:0], 32'd0}));

    // Count value: software write first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (wr_lo || wr_hi) cnt_q <= cnt_wv;
        else if (inc)            cnt_q <= cnt_q + CYC_W'(1);
    end

    // Sticky overflow flag written through high-word bit 31.
    always_ff @(posedge clk) begin
        if (!rst_n)     of_q <= 1'b0;
        else if (wr_hi) of_q <= wdata[31];
        else if (wrap)  of_q <= 1'b1;
    end
endmodule

// File: rtl/tpb_top.sv
// Performance counter bank top: register decode, inhibit word, read mux,
// interrupt-pending flag and NUM_CTR event counters beside one cycle counter.
// Assumes single-cycle writes and combinational reads on a word address.
module tpb_top
    import tpb_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 40,
    parameter int CYC_W   = 63
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_we,
    input  logic [WADDR_W-1:0]       reg_waddr,
    input  logic [31:0]              reg_wdata,
    output logic [31:0]              reg_rdata,
    input  logic [NUM_EVT_TYPES-1:0] evt_pulse,
    input  logic [DEV_W-1:0]         tag_did,
    input  logic [PROC_W-1:0]        tag_pid,
    input  logic [DEV_W-1:0]         tag_gscid,
    input  logic [PROC_W-1:0]        tag_pscid,
    output logic                     irq_pend
);
    localparam logic [31:0] IMPL_MASK = 32'((64'd1 << (NUM_CTR + 1)) - 64'd1);

    logic [11:0]      addr;
    logic             in_ctr;
    logic             in_sel;
    logic             hi_word;
    logic [4:0]       cslot;
    logic [4:0]       sslot0;
    logic [31:0]      inh_q;
    logic [31:0]      ovf_stat;
    logic [CYC_W-1:0] cyc_cnt;
    logic             cyc_of;
    logic             cyc_wrap;
    logic             wrap_any;
    logic             pend_q;

    logic [CTR_W-1:0] ctr_q [1:NUM_CTR];
    sel_t             sel_q [1:NUM_CTR];
    logic [NUM_CTR:1] evt_of;
    logic [NUM_CTR:1] evt_wrap;

    // Address decode.
    assign addr    = {reg_waddr, 2'b00};
    assign in_ctr  = (addr >= OFF_CTR) && (addr < OFF_SEL);
    assign in_sel  = (addr >= OFF_SEL) && (addr < OFF_SEL_END);
    assign hi_word = addr[2];
    assign cslot   = 5'((addr - OFF_CTR) >> 3);
    assign sslot0  = 5'((addr - OFF_SEL) >> 3);

    tpb_cyc_ctr #(.CYC_W(CYC_W)) u_cyc (
        .clk    (clk),
        .rst_n  (rst_n),
        .inhibit(inh_q[0]),
        .wr_lo  (reg_we && in_ctr && !hi_word && cslot == 5'd0),
        .wr_hi  (reg_we && in_ctr && hi_word && cslot == 5'd0),
        .wdata  (reg_wdata),
        .cnt_q  (cyc_cnt),
        .of_q   (cyc_of),
        .wrap   (cyc_wrap)
    );

    for (genvar i = 1; i <= NUM_CTR; i++) begin : g_ctr
        logic hit_c;
        logic hit_s;
        assign hit_c = reg_we && in_ctr && (int'(cslot) == i);
        assign hit_s = reg_we && in_sel && (int'(sslot0) + 1 == i);

        tpb_evt_ctr #(.CTR_W(CTR_W)) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt_pulse(evt_pulse),
            .tag_did  (tag_did),
            .tag_gscid(tag_gscid),
            .tag_pid  (tag_pid),
            .tag_pscid(tag_pscid),
            .inhibit  (inh_q[i]),
            .wr_cnt_lo(hit_c && !hi_word),
            .wr_cnt_hi(hit_c && hi_word),
            .wr_sel_lo(hit_s && !hi_word),
            .wr_sel_hi(hit_s && hi_word),
            .wdata    (reg_wdata),
            .cnt_q    (ctr_q[i]),
            .sel_q    (sel_q[i]),
            .of_q     (evt_of[i]),
            .wrap     (evt_wrap[i])
        );
    end

    assign ovf_stat = 32'({evt_of, cyc_of});
    assign wrap_any = cyc_wrap || (|evt_wrap);
    assign irq_pend = pend_q;

    // Inhibit word: only implemented counter bits stick.
    always_ff @(posedge clk) begin
        if (!rst_n)                        inh_q <= IMPL_MASK;
        else if (reg_we && addr == OFF_INH) inh_q <= reg_wdata & IMPL_MASK;
    end

    // Interrupt pending: set by any wrap, cleared by writing one to bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend_q <= 1'b0;
        else if (wrap_any) pend_q <= 1'b1;
        else if (reg_we && addr == OFF_IRQ && reg_wdata[0]) pend_q <= 1'b0;
    end

    // Read mux.
    always_comb begin
        logic [63:0] w64;
        reg_rdata = 32'd0;
        w64       = 64'd0;
        if (addr == OFF_IRQ)      reg_rdata = {31'd0, pend_q};
        else if (addr == OFF_OVF) reg_rdata = ovf_stat;
        else if (addr == OFF_INH) reg_rdata = inh_q;
        else if (in_ctr && cslot == 5'd0) begin
            w64       = {cyc_of, 63'(cyc_cnt)};
            reg_rdata = hi_word ? w64[63:32] : w64[31:0];
        end
        for (int i = 1; i <= NUM_CTR; i++) begin
            if (in_ctr && int'(cslot) == i) begin
                w64       = 64'(ctr_q[i]);
                reg_rdata = hi_word ? w64[63:32] : w64[31:0];
            end
            if (in_sel && int'(sslot0) + 1 == i) begin
                w64       = {evt_of[i], sel_q[i]};
                reg_rdata = hi_word ? w64[63:32] : w64[31:0];
            end
        end
    end
endmodule

// File: rtl/tpb_checker.sv
// Temporal checks on the counter bank, bound to tpb_top. Watches the bus,
// the inhibit word, the cycle counter and the wrap pulses.
module tpb_checker #(
    parameter int NUM_CTR = 4,
    parameter int CYC_W   = 63
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [9:0]       reg_waddr,
    input logic [31:0]      reg_wdata,
    input logic             irq_pend,
    input logic [31:0]      inh_q,
    input logic [CYC_W-1:0] cyc_cnt,
    input logic             wrap_any
);
    localparam logic [31:0] IMPL = 32'((64'd1 << (NUM_CTR + 1)) - 64'd1);

    logic irq_clr;
    logic cyc_lo_wr;
    assign irq_clr   = reg_we && ({reg_waddr, 2'b00} == 12'h050) && reg_wdata[0];
    assign cyc_lo_wr = reg_we && ({reg_waddr, 2'b00} == 12'h060);

    a_r2_inh_warl: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q & ~IMPL) == 32'd0);
    a_r4_cyc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!inh_q[0] && !reg_we) |=> (cyc_cnt == $past(cyc_cnt) + CYC_W'(1)));
    a_r5_cyc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q[0] && !reg_we) |=> $stable(cyc_cnt));
    a_r10_pend_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_any |=> irq_pend);
    a_r11_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !irq_clr) |=> irq_pend);
    a_r12_cyc_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_lo_wr |=> (cyc_cnt[31:0] == $past(reg_wdata)));
endmodule

bind tpb_top tpb_checker #(.NUM_CTR(NUM_CTR), .CYC_W(CYC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata),
    .irq_pend (irq_pend),
    .inh_q    (inh_q),
    .cyc_cnt  (cyc_cnt),
    .wrap_any (wrap_any)
);

// File: tb/test_tpb_top.sv
// Directed bench for tpb_top with defaults NUM_CTR=4, CTR_W=40, CYC_W=63.
module test_tpb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic [23:0] tag_did = '0;
    logic [19:0] tag_pid = '0;
    logic [23:0] tag_gscid = '0;
    logic [19:0] tag_pscid = '0;
    logic        irq_pend;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    tpb_top i_tpb_top (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .tag_did(tag_did), .tag_pid(tag_pid), .tag_gscid(tag_gscid),
        .tag_pscid(tag_pscid), .irq_pend(irq_pend)
    );

    function automatic logic [11:0] ctr_lo(int n); return 12'(12'h060 + 8 * n); endfunction
    function automatic logic [11:0] sel_lo(int n); return 12'(12'h160 + 8 * (n - 1)); endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a[11:2]; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_waddr = a[11:2];
        #1 v = reg_rdata;
    endtask

    task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Hold events and tags for exactly n rising edges.
    task automatic pulse(logic [7:0] ev, logic [23:0] did, logic [23:0] gsc,
                         logic [19:0] pid, logic [19:0] psc, int n);
        @(negedge clk);
        evt_pulse = ev; tag_did = did; tag_gscid = gsc; tag_pid = pid; tag_pscid = psc;
        repeat (n) @(negedge clk);
        evt_pulse = '0; tag_did = '0; tag_gscid = '0; tag_pid = '0; tag_pscid = '0;
    endtask

    task automatic t_reset();
        rd_chk("R1 inhibit", 12'h05C, 32'h1F);
        rd_chk("R1 status", 12'h058, 32'h0);
        rd_chk("R1 cycle lo", 12'h060, 32'h0);
        rd_chk("R1 ctr1 lo", ctr_lo(1), 32'h0);
        chk("R1 irq", {31'd0, irq_pend}, 32'h0);
    endtask

    task automatic t_warl();
        wr(12'h05C, 32'hFFFF_FFFF);
        rd_chk("R2 inhibit all ones", 12'h05C, 32'h1F);
        wr(12'h05C, 32'hFFFF_FFE0);
        rd_chk("R2 inhibit high bits", 12'h05C, 32'h0);
        wr(12'h05C, 32'h1F);
        wr(ctr_lo(1) + 12'd4, 32'hFFFF_FFFF);
        rd_chk("R3 ctr1 width", ctr_lo(1) + 12'd4, 32'hFF);
        wr(ctr_lo(1) + 12'd4, 32'h0);
        wr(ctr_lo(5), 32'hFFFF_FFFF);
        rd_chk("R3 unimplemented ctr5", ctr_lo(5), 32'h0);
        wr(12'h064, 32'h7FFF_FFFF);
        rd_chk("R3 cycle hi", 12'h064, 32'h7FFF_FFFF);
        wr(12'h064, 32'h0);
    endtask

    task automatic t_cycle();
        logic [31:0] v0, v1;
        wr(12'h05C, 32'h1E);
        @(negedge clk); reg_waddr = 10'(12'h060 >> 2); #1 v0 = reg_rdata;
        repeat (10) @(negedge clk);
        #1 v1 = reg_rdata;
        chk("R4 cycle step", v1 - v0, 32'd10);
        wr(12'h05C, 32'h1F);
        @(negedge clk); reg_waddr = 10'(12'h060 >> 2); #1 v0 = reg_rdata;
        repeat (5) @(negedge clk);
        #1 v1 = reg_rdata;
        chk("R5 cycle hold", v1, v0);
    endtask

    task automatic t_events();
        wr(sel_lo(1), 32'h1);
        wr(12'h05C, 32'h19);
        pulse(8'h01, 0, 0, 0, 0, 5);
        pulse(8'h02, 0, 0, 0, 0, 3);
        rd_chk("R6 id1 count", ctr_lo(1), 32'd5);
        rd_chk("R6 id0 no count", ctr_lo(2), 32'd0);
        wr(sel_lo(2), 32'h4);
        pulse(8'h08, 0, 0, 0, 0, 4);
        rd_chk("R6 id4 count", ctr_lo(2), 32'd4);
        rd_chk("R6 other ignored", ctr_lo(1), 32'd5);
        wr(12'h05C, 32'h1B);
        pulse(8'h01, 0, 0, 0, 0, 3);
        rd_chk("R5 inhibited event", ctr_lo(1), 32'd5);
        wr(12'h05C, 32'h01);
    endtask

    task automatic t_filters();
        wr(sel_lo(3), 32'h1);
        wr(sel_lo(3) + 12'd4, 32'h2000_1230);
        pulse(8'h01, 24'h123, 0, 0, 0, 3);
        pulse(8'h01, 24'h124, 0, 0, 0, 2);
        rd_chk("R7 device match", ctr_lo(3), 32'd3);
        wr(ctr_lo(3), 32'h0);
        wr(sel_lo(3) + 12'd4, 32'h6000_1230);
        pulse(8'h01, 24'h123, 24'h999, 0, 0, 2);
        pulse(8'h01, 24'h0, 24'h123, 0, 0, 4);
        rd_chk("R7 guest context", ctr_lo(3), 32'd4);
        wr(sel_lo(4), 32'h8001);
        wr(sel_lo(4) + 12'd4, 32'h2000_1070);
        pulse(8'h01, 24'h10A, 0, 0, 0, 3);
        pulse(8'h01, 24'h110, 0, 0, 0, 2);
        pulse(8'h01, 24'h100, 0, 0, 0, 1);
        rd_chk("R9 partial range", ctr_lo(4), 32'd4);
        wr(sel_lo(4), 32'hABCD_0001);
        wr(sel_lo(4) + 12'd4, 32'h1000_0005);
        wr(ctr_lo(4), 32'h0);
        pulse(8'h01, 0, 0, 20'h5ABCD, 0, 2);
        pulse(8'h01, 0, 0, 20'h5ABCE, 0, 3);
        rd_chk("R8 process match", ctr_lo(4), 32'd2);
    endtask

    task automatic t_overflow();
        wr(ctr_lo(1) + 12'd4, 32'hFF);
        wr(ctr_lo(1), 32'hFFFF_FFFE);
        pulse(8'h01, 0, 0, 0, 0, 1);
        rd_chk("R10 at max", ctr_lo(1), 32'hFFFF_FFFF);
        chk("R10 no irq yet", {31'd0, irq_pend}, 32'h0);
        pulse(8'h01, 0, 0, 0, 0, 1);
        rd_chk("R10 wrap lo", ctr_lo(1), 32'h0);
        rd_chk("R10 wrap hi", ctr_lo(1) + 12'd4, 32'h0);
        rd_chk("R10 status", 12'h058, 32'h2);
        rd_chk("R10 selector flag", sel_lo(1) + 12'd4, 32'h8000_0000);
        chk("R10 irq", {31'd0, irq_pend}, 32'h1);
        repeat (3) @(negedge clk);
        wr(12'h050, 32'h0);
        chk("R11 irq sticky", {31'd0, irq_pend}, 32'h1);
        wr(12'h050, 32'h1);
        chk("R11 irq cleared", {31'd0, irq_pend}, 32'h0);
        rd_chk("R11 flag sticky", 12'h058, 32'h2);
        wr(sel_lo(1) + 12'd4, 32'h0);
        rd_chk("R11 flag cleared", 12'h058, 32'h0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = ctr_lo(1) >> 2; reg_wdata = 32'h55; evt_pulse = 8'h01;
        @(negedge clk);
        reg_we = 1'b0; evt_pulse = 8'h00;
        rd_chk("R12 write wins", ctr_lo(1), 32'h55);
        pulse(8'h01, 0, 0, 0, 0, 1);
        rd_chk("R12 counts after", ctr_lo(1), 32'h56);
    endtask

    task automatic t_cyc_overflow();
        wr(12'h064, 32'h7FFF_FFFF);
        wr(12'h060, 32'hFFFF_FFF0);
        rd_chk("R3 cycle preset", 12'h064, 32'h7FFF_FFFF);
        wr(12'h05C, 32'h0);
        repeat (30) @(negedge clk);
        wr(12'h05C, 32'h1);
        rd_chk("R10 cycle flag", 12'h064, 32'h8000_0000);
        rd_chk("R10 cycle status", 12'h058, 32'h1);
        chk("R10 cycle irq", {31'd0, irq_pend}, 32'h1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_warl();
        t_cycle();
        t_events();
        t_filters();
        t_overflow();
        t_priority();
        t_cyc_overflow();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule